// File: doc/BRIEF.md
# Clock Phase Skew Calibration Sequencer

This block aligns a recovered clock to a reference. It drives a fine phase shifter outside the block, one increment per request. It reads a single-bit phase detector to find where that detector flips from low to high. After every shifter step it waits for the shifter's completion strobe. It then holds off for a settling interval, so the downstream loop can recover before anything else happens.

A run begins with a start pulse. The block first looks for a position where three qualified detector readings, spaced a margin of steps apart, all agree. If that agreed value is high, it walks forward out of the high region and then jumps one margin further into the low region. From there it steps forward until the qualified reading turns high. It records the net number of steps taken to reach that edge, adds the programmed skew in extra forward steps, and finishes with a done pulse.

The recorded step count converts to degrees as count × 360 / 448, because one full clock period is 448 shifter increments.

Top module: `phase_align_seq`

## Requirements
- R1: A qualified detector reading is formed from QUAL_READS (default 32) consecutive reads of `sample_i`. It is 1 only when every one of those reads is 1; a single 0 read makes it 0.
- R2: For each step, `shift_req_o` rises with `shift_dir_o` valid (1 = advance, 0 = retard). Both hold unchanged until `shift_done_i` is seen high, and the request drops in the following cycle.
- R3: After a step's done strobe, at least SETTLE_CYCLES clock cycles pass with `shift_req_o` low before the next request. The default is 500 µs at CLK_HZ.
- R4: The stability check takes a qualified reading, advances MARGIN_STEPS (default 28), reads again, advances MARGIN_STEPS, and reads a third time. If all three agree, it retards MARGIN_STEPS and keeps the middle value. Otherwise it repeats from the current position with no retard.
- R5: If the stable value is 1, the block advances one step per qualified reading while the reading stays 1. It then advances MARGIN_STEPS more.
- R6: From the low region, the block advances one step per qualified reading until the reading is 1. That position is the low-to-high transition.
- R7: After the transition, the block advances exactly the skew value captured from `skew_i` at start. A skew of 0 adds no steps.
- R8: `step_count_o` gives the net step count at the transition: advances minus retards, counted since start. It is updated in the cycle `done_o` is high and holds its value at all other times.
- R9: `busy_o` is high from the cycle after an accepted start until the sequence ends. `done_o` is a one-cycle pulse with `busy_o` low. A start while busy is ignored.
- R10: Under reset, `shift_req_o`, `shift_dir_o`, `busy_o`, `done_o` and `step_count_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a calibration run when idle |
| skew_i | input | SKEW_W | Extra forward steps applied after the edge; captured at start |
| shift_req_o | output | 1 | Phase step request, held until acknowledged |
| shift_dir_o | output | 1 | Step direction, 1 advance, 0 retard |
| shift_done_i | input | 1 | Shifter completion strobe |
| sample_i | input | 1 | Phase detector bit |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| step_count_o | output | CNT_W | Net steps from start to the low-to-high transition |

## Verification
The assertions assume the shifter raises `shift_done_i` only while a request is pending, and only once for each request. The bench's shifter model keeps to this: it acknowledges each request exactly once, after a random latency of 0 to 3 cycles. The detector model is a clean square function of the modelled phase position, with a half period far wider than the margin. The only exception is one directed case, where the detector bit toggles every cycle so that no read window is ever all ones. Edges inside the three-point window come from choosing the starting offset, never from random noise.

// File: rtl/phase_align_pkg.sv
package phase_align_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SAMP_A,
    ST_JUMP_A,
    ST_SAMP_B,
    ST_JUMP_B,
    ST_SAMP_C,
    ST_BACKOFF,
    ST_EXIT_SAMP,
    ST_EXIT_STEP,
    ST_EXIT_MARGIN,
    ST_SEEK_SAMP,
    ST_SEEK_STEP,
    ST_SKEW,
    ST_FINISH
  } seq_state_t;
endpackage

// File: rtl/pa_step_engine.sv
// One phase step: request, wait for the acknowledge, then settle.
module pa_step_engine #(
  parameter int SETTLE_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  input  logic dir_i,
  output logic shift_req_o,
  output logic shift_dir_o,
  input  logic shift_done_i,
  output logic fin_o
);
  localparam int SW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYCLES - 1);

  logic          settling;
  logic [SW-1:0] settle_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_req_o <= 1'b0;
      shift_dir_o <= 1'b0;
      fin_o       <= 1'b0;
      settling    <= 1'b0;
      settle_cnt  <= '0;
    end else begin
      fin_o <= 1'b0;
      if (go_i && !shift_req_o && !settling) begin
        shift_req_o <= 1'b1;
        shift_dir_o <= dir_i;
      end else if (shift_req_o && shift_done_i) begin
        shift_req_o <= 1'b0;
        settling    <= 1'b1;
        settle_cnt  <= '0;
      end else if (settling) begin
        if (settle_cnt == SETTLE_LAST) begin
          settling <= 1'b0;
          fin_o    <= 1'b1;
        end else begin
          settle_cnt <= settle_cnt + SW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pa_sample_qual.sv
// Qualifies the detector bit: 1 only if all READS consecutive reads are 1.
module pa_sample_qual #(
  parameter int READS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  input  logic sample_i,
  output logic valid_o,
  output logic result_o
);
  localparam int CW = (READS > 1) ? $clog2(READS) : 1;
  localparam logic [CW-1:0] READ_LAST = CW'(READS - 1);

  logic          running;
  logic          acc;
  logic [CW-1:0] rd_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      running  <= 1'b0;
      acc      <= 1'b1;
      rd_cnt   <= '0;
      valid_o  <= 1'b0;
      result_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (go_i && !running) begin
        running <= 1'b1;
        acc     <= 1'b1;
        rd_cnt  <= '0;
      end else if (running) begin
        acc <= acc & sample_i;
        if (rd_cnt == READ_LAST) begin
          running  <= 1'b0;
          valid_o  <= 1'b1;
          result_o <= acc & sample_i;
        end else begin
          rd_cnt <= rd_cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/phase_align_seq.sv
module phase_align_seq
  import phase_align_pkg::*;
#(
  parameter int CLK_HZ        = 100_000_000,
  parameter int SETTLE_US     = 500,
  parameter int SETTLE_CYCLES = CLK_HZ / 1_000_000 * SETTLE_US,
  parameter int QUAL_READS    = 32,
  parameter int MARGIN_STEPS  = 28,
  parameter int SKEW_W        = 16,
  parameter int CNT_W         = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [SKEW_W-1:0] skew_i,
  output logic              shift_req_o,
  output logic              shift_dir_o,
  input  logic              shift_done_i,
  input  logic              sample_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  step_count_o
);
  localparam int MW = $clog2(MARGIN_STEPS + 1);
  localparam logic [MW-1:0] MARGIN_LAST = MW'(MARGIN_STEPS - 1);

  seq_state_t        st;
  logic              waiting;
  logic              step_go, step_dir, step_fin;
  logic              samp_go, samp_valid, samp_res;
  logic [MW-1:0]     rep;
  logic              s_a, s_b;
  logic [SKEW_W-1:0] skew_left;
  logic [CNT_W-1:0]  run_cnt, trans_cnt;
  logic              is_samp_st, is_step_st, dir_nxt;

  pa_step_engine #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_step (
    .clk(clk), .rst(rst), .go_i(step_go), .dir_i(step_dir),
    .shift_req_o(shift_req_o), .shift_dir_o(shift_dir_o),
    .shift_done_i(shift_done_i), .fin_o(step_fin)
  );

  pa_sample_qual #(.READS(QUAL_READS)) u_qual (
    .clk(clk), .rst(rst), .go_i(samp_go), .sample_i(sample_i),
    .valid_o(samp_valid), .result_o(samp_res)
  );

  always_comb begin
    is_samp_st = (st == ST_SAMP_A) || (st == ST_SAMP_B) || (st == ST_SAMP_C) ||
                 (st == ST_EXIT_SAMP) || (st == ST_SEEK_SAMP);
    is_step_st = (st == ST_JUMP_A) || (st == ST_JUMP_B) || (st == ST_BACKOFF) ||
                 (st == ST_EXIT_STEP) || (st == ST_EXIT_MARGIN) ||
                 (st == ST_SEEK_STEP) || (st == ST_SKEW);
    dir_nxt    = (st != ST_BACKOFF);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      waiting      <= 1'b0;
      step_go      <= 1'b0;
      step_dir     <= 1'b0;
      samp_go      <= 1'b0;
      rep          <= '0;
      s_a          <= 1'b0;
      s_b          <= 1'b0;
      skew_left    <= '0;
      run_cnt      <= '0;
      trans_cnt    <= '0;
      busy_o       <= 1'b0;
      done_o       <= 1'b0;
      step_count_o <= '0;
    end else begin
      step_go <= 1'b0;
      samp_go <= 1'b0;
      done_o  <= 1'b0;

      // launch the operation of the current state
      if (is_samp_st && !waiting) begin
        samp_go <= 1'b1;
        waiting <= 1'b1;
      end
      if (is_step_st && !waiting) begin
        step_go  <= 1'b1;
        step_dir <= dir_nxt;
        waiting  <= 1'b1;
      end
      if (waiting && (samp_valid || step_fin)) waiting <= 1'b0;

      if (step_fin) run_cnt <= step_dir ? run_cnt + CNT_W'(1) : run_cnt - CNT_W'(1);

      case (st)
        ST_IDLE: if (start_i) begin
          busy_o    <= 1'b1;
          run_cnt   <= '0;
          skew_left <= skew_i;
          rep       <= '0;
          waiting   <= 1'b0;
          st        <= ST_SAMP_A;
        end
        ST_SAMP_A: if (samp_valid) begin
          s_a <= samp_res;
          st  <= ST_JUMP_A;
        end
        ST_JUMP_A: if (step_fin) begin
          if (rep == MARGIN_LAST) begin
            rep <= '0;
            st  <= ST_SAMP_B;
          end else rep <= rep + MW'(1);
        end
        ST_SAMP_B: if (samp_valid) begin
          s_b <= samp_res;
          st  <= ST_JUMP_B;
        end
        ST_JUMP_B: if (step_fin) begin
          if (rep == MARGIN_LAST) begin
            rep <= '0;
            st  <= ST_SAMP_C;
          end else rep <= rep + MW'(1);
        end
        ST_SAMP_C: if (samp_valid) begin
          st <= (s_a == s_b && s_b == samp_res) ? ST_BACKOFF : ST_SAMP_A;
        end
        ST_BACKOFF: if (step_fin) begin
          if (rep == MARGIN_LAST) begin
            rep <= '0;
            st  <= s_b ? ST_EXIT_SAMP : ST_SEEK_SAMP;
          end else rep <= rep + MW'(1);
        end
        ST_EXIT_SAMP: if (samp_valid) begin
          st <= samp_res ? ST_EXIT_STEP : ST_EXIT_MARGIN;
        end
        ST_EXIT_STEP: if (step_fin) st <= ST_EXIT_SAMP;
        ST_EXIT_MARGIN: if (step_fin) begin
          if (rep == MARGIN_LAST) begin
            rep <= '0;
            st  <= ST_SEEK_SAMP;
          end else rep <= rep + MW'(1);
        end
        ST_SEEK_SAMP: if (samp_valid) begin
          if (samp_res) begin
            trans_cnt <= run_cnt;
            st        <= (skew_left == '0) ? ST_FINISH : ST_SKEW;
          end else st <= ST_SEEK_STEP;
        end
        ST_SEEK_STEP: if (step_fin) st <= ST_SEEK_SAMP;
        ST_SKEW: if (step_fin) begin
          skew_left <= skew_left - SKEW_W'(1);
          if (skew_left == SKEW_W'(1)) st <= ST_FINISH;
        end
        ST_FINISH: begin
          busy_o       <= 1'b0;
          done_o       <= 1'b1;
          step_count_o <= trans_cnt;
          st           <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pa_seq_checker.sv
module pa_seq_checker #(
  parameter int SETTLE_CYCLES = 3,
  parameter int CNT_W         = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             shift_req_o,
  input logic             shift_dir_o,
  input logic             shift_done_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [CNT_W-1:0] step_count_o
);
  logic [31:0] gap;

  always_ff @(posedge clk) begin
    if (rst) gap <= 32'(SETTLE_CYCLES);
    else if (shift_req_o) gap <= '0;
    else if (gap < 32'(SETTLE_CYCLES)) gap <= gap + 32'd1;
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    shift_req_o && !shift_done_i |=> shift_req_o && $stable(shift_dir_o)); // R2
  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (rst)
    shift_req_o && shift_done_i |=> !shift_req_o); // R2
  AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(shift_req_o) |-> gap >= 32'(SETTLE_CYCLES)); // R3
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(step_count_o)); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o && $past(busy_o)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy_o && !done_o |-> !shift_req_o); // R9
endmodule

bind phase_align_seq pa_seq_checker #(.SETTLE_CYCLES(SETTLE_CYCLES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .shift_req_o(shift_req_o), .shift_dir_o(shift_dir_o),
  .shift_done_i(shift_done_i), .busy_o(busy_o), .done_o(done_o),
  .step_count_o(step_count_o)
);

// File: tb/phase_align_seq_test.sv
module phase_align_seq_test;
  localparam int SETTLE = 3;
  localparam int SKW    = 16;
  localparam int CW     = 16;
  localparam int PER    = 224;
  localparam int MARGIN = 28;

  logic clk = 0, rst = 1, start_i = 0, shift_done_i = 0, sample_i = 0;
  logic [SKW-1:0] skew_i = '0;
  logic shift_req_o, shift_dir_o, busy_o, done_o;
  logic [CW-1:0] step_count_o;

  int total = 0, bad = 0;
  int pos = 0, off = 0, adv = 0, ret = 0, low_run = SETTLE;
  bit glitch = 0, acked = 0, prev_req = 0, prev_dir = 0, finished = 0;
  int lat = 0;

  always #10 clk = ~clk;

  phase_align_seq #(.SETTLE_CYCLES(SETTLE), .QUAL_READS(32), .MARGIN_STEPS(MARGIN),
                    .SKEW_W(SKW), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .skew_i(skew_i),
    .shift_req_o(shift_req_o), .shift_dir_o(shift_dir_o), .shift_done_i(shift_done_i),
    .sample_i(sample_i), .busy_o(busy_o), .done_o(done_o), .step_count_o(step_count_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit det(input int p, input int o);
    int m = ((p + o) % PER + PER) % PER;
    return m >= PER / 2;
  endfunction

  // reference walk built from R4..R7
  function automatic void ref_run(input int o, input int sk, output int tr, output int fp);
    int p = 0;
    bit a, b, c;
    while (1) begin
      a = det(p, o); p += MARGIN;
      b = det(p, o); p += MARGIN;
      c = det(p, o);
      if (a == b && b == c) begin
        p -= MARGIN;
        break;
      end
    end
    if (b) begin
      while (det(p, o)) p++;
      p += MARGIN;
    end
    while (!det(p, o)) p++;
    tr = p;
    fp = p + sk;
  endfunction

  // shifter and detector model
  initial forever begin
    @(negedge clk);
    if (rst) begin
      shift_done_i = 0; acked = 0; prev_req = 0; low_run = SETTLE;
    end else begin
      shift_done_i = 0;
      if (shift_req_o) begin
        if (!prev_req && low_run < SETTLE) chk(0, "R3 settle gap", low_run, SETTLE);
        if (prev_req && shift_dir_o != prev_dir) chk(0, "R2 dir changed", shift_dir_o, prev_dir);
        if (!acked) begin
          if (lat == 0) begin
            shift_done_i = 1; acked = 1;
            if (shift_dir_o) begin pos++; adv++; end else begin pos--; ret++; end
          end else lat--;
        end
        low_run = 0;
      end else begin
        if (prev_req && !acked) chk(0, "R2 request dropped early", 0, 1);
        acked = 0;
        lat = $urandom % 4;
        low_run++;
      end
      prev_req = shift_req_o;
      prev_dir = shift_dir_o;
    end
    sample_i = glitch ? ~sample_i : det(pos, off);
  end

  task automatic run_case(input int o, input int sk, input bit restart);
    int tr, fp, n;
    bit seen;
    ref_run(o, sk, tr, fp);
    off = o; pos = 0; adv = 0; ret = 0;
    @(negedge clk);
    skew_i = SKW'(sk); start_i = 1;
    @(negedge clk);
    start_i = 0; skew_i = SKW'(sk + 7);
    @(negedge clk);
    chk(busy_o == 1, "R9 busy after start", busy_o, 1);
    seen = 0; n = 0;
    while (!seen && n < 40000) begin
      @(negedge clk);
      n++;
      if (restart && n == 600) start_i = 1;
      if (restart && n == 601) start_i = 0;
      if (done_o) seen = 1;
    end
    chk(seen, "R9 done reached", seen, 1);
    chk(busy_o == 0, "R9 busy low at done", busy_o, 0);
    chk(int'(step_count_o) == tr, "R8 R6 transition count", step_count_o, tr);
    chk(pos == fp, "R7 R5 final position", pos, fp);
    chk(ret == MARGIN, "R4 single backoff", ret, MARGIN);
    @(negedge clk);
    chk(done_o == 0, "R9 done one cycle", done_o, 0);
    chk(int'(step_count_o) == tr, "R8 count held", step_count_o, tr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5e_a117));
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(!shift_req_o && !shift_dir_o && !busy_o && !done_o && step_count_o == '0,
        "R10 reset outputs", {shift_req_o, shift_dir_o, busy_o, done_o}, 0);
    rst = 0;
    // directed: low start, high start at region entry, edge inside window
    run_case(0, 32, 0);
    run_case(PER / 2, 0, 0);
    run_case(PER / 2 - 30, 5, 0);
    // R9 start while busy ignored, R7 skew captured at start
    run_case(150, 3, 1);
    for (int i = 0; i < 3; i++) run_case($urandom % PER, $urandom % 40, 0);
    // R1: detector toggling every cycle never qualifies as 1
    glitch = 1; pos = 0; ret = 0;
    @(negedge clk); start_i = 1; skew_i = 0;
    @(negedge clk); start_i = 0;
    repeat (4000) @(negedge clk);
    chk(busy_o == 1 && done_o == 0, "R1 no qualified one", busy_o, 1);
    chk(ret == MARGIN, "R1 stable low region found", ret, MARGIN);
    rst = 1; glitch = 0;
    repeat (2) @(negedge clk);
    chk(!shift_req_o && !busy_o && step_count_o == '0, "R10 reset aborts run", busy_o, 0);
    rst = 0;
    run_case(40, 1, 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule